// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide ATA Register Bridge

This bridge lets a host with an 8-bit I/O bus reach the task-file registers of a 16-bit ATA device. The host sees a window of sixteen byte addresses placed at a parameterised base. Only the four lowest address bits pick a register inside that window. Most offsets reach a single device register directly. The sector data register is 16 bits wide, so it is reached through a byte-wide holding register that the host can see. That holding register supplies or receives the upper half of each data word.

To write a data word, the host first stores the upper byte in the holding register. It then writes the lower byte to the data offset, and that write issues one 16-bit device write. To read a data word, the host reads the data offset. That read issues one 16-bit device read, returns the lower byte and parks the upper byte in the holding register, where a second read picks it up. The device side is a synchronous register port. A command-block select and a control-block select qualify a 3-bit register index, and single-cycle read and write strobes carry the 16-bit data.

Top module: `ide_byte_bridge`

## Requirements
- R1: A host access decodes only when address bits above bit 3 equal the same bits of parameter `BASE`. An access outside the window causes no device strobe, and `hostRdOe` stays low in the following cycle.
- R2: A host write to offset 8 stores the host byte in the holding register and raises neither `ataRd` nor `ataWr`.
- R3: A host write to offset 0 raises `ataWr` for exactly that cycle, with `ataCmdSel`=1 and `ataRegAddr`=0. `ataWrData` carries the holding register in bits 15:8 and the host byte in bits 7:0.
- R4: A host read at offset 0 raises `ataRd` with `ataCmdSel`=1 and `ataRegAddr`=0. In the next cycle the host gets bits 7:0 of the device word, and the holding register now contains bits 15:8 of that word.
- R5: A host read at offset 8 returns the holding register and raises no device strobe.
- R6: Offsets 1 to 7 map to command-block register indexes 1 to 7. A write drives the host byte in `ataWrData` bits 7:0 and zero in bits 15:8. A read returns `ataRdData` bits 7:0.
- R7: Offset 14 maps to the control block at `ataRegAddr`=6 with `ataCtlSel`=1. A write drives device control there, and a read returns the alternate status byte.
- R8: Offsets 9 to 13 and 15 read as 0xFF. A write to any of them causes no device strobe and leaves the holding register unchanged.
- R9: The holding register is zero after reset. A write at offset 8 and a read at offset 0 both load it, and the most recent of the two sets its value.
- R10: A device strobe is issued in the same cycle as the host strobe. Host read data and `hostRdOe` appear in the next cycle, and `hostRdOe` is high for one cycle per read.
- R11: If `hostRd` and `hostWr` are both high in one cycle, only the write is carried out. No device read is issued, and `hostRdOe` stays low in the next cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host I/O address |
| hostWrData | input | HOST_W | Host write byte |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRdData | output | HOST_W | Host read byte, valid when hostRdOe is high |
| hostRdOe | output | 1 | Host read data drive enable |
| ataCmdSel | output | 1 | Command-block select |
| ataCtlSel | output | 1 | Control-block select |
| ataRegAddr | output | 3 | Device register index |
| ataRd | output | 1 | Device read strobe |
| ataWr | output | 1 | Device write strobe |
| ataWrData | output | 2*HOST_W | Device write word |
| ataRdData | input | 2*HOST_W | Device read word, valid during ataRd |

## Verification
Two operations can fall in the same cycle. A host read strobe and a host write strobe can both be high at one command-register offset. The holding register can also be loaded from both sides, by a data-word read and by a write at offset 8. The bench drives both host strobes together at offset 3. It then expects the device register to receive the written byte, the device read count to stay unchanged, and no drive enable in the next cycle. For the holding register, the bench alternates a write at offset 8 with a data-word read. After each step it checks that the next data-word write carries the byte from the most recent of the two.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  localparam int OFF_W = 4;
  localparam int IDX_W = 3;

  localparam logic [OFF_W-1:0] OFF_WORD = 4'd0;
  localparam logic [OFF_W-1:0] OFF_HOLD = 4'd8;
  localparam logic [OFF_W-1:0] OFF_CTRL = 4'd14;

  localparam logic [IDX_W-1:0] IDX_WORD = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ALT  = 3'd6;

  typedef enum logic [2:0] {
    KIND_WORD,
    KIND_PASS,
    KIND_HOLD,
    KIND_CTRL,
    KIND_DEAD
  } offKind_e;

  typedef enum logic [1:0] {
    RSRC_DEV,
    RSRC_HOLD,
    RSRC_ONES
  } rdSrc_e;

  typedef enum logic [1:0] {
    BLK_NONE,
    BLK_CMD,
    BLK_CTL
  } ataBlk_e;

  typedef struct packed {
    logic             devRd;
    logic             devWr;
    ataBlk_e          blk;
    logic [IDX_W-1:0] regIdx;
    logic             wordXfer;
    logic             holdLoad;
    logic             rdCapture;
    rdSrc_e           rdSrc;
  } ctlStrobe_t;

  function automatic offKind_e classifyOffset(input logic [OFF_W-1:0] off);
    offKind_e kind;
    if (off == OFF_WORD)                           kind = KIND_WORD;
    else if (off == OFF_HOLD)                      kind = KIND_HOLD;
    else if (off == OFF_CTRL)                      kind = KIND_CTRL;
    else if (off[OFF_W-1] == 1'b0)                 kind = KIND_PASS;
    else                                           kind = KIND_DEAD;
    return kind;
  endfunction
endpackage

// File: rtl/ibb_ctrl.sv
module ibb_ctrl
  import ibb_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0300
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  output ctlStrobe_t        strobe
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic             inWindow;
  logic             wrGo;
  logic             rdGo;
  logic [OFF_W-1:0] offset;
  offKind_e         kind;

  generate
    if (TAG_W > 0) begin : g_tag
      assign inWindow = (hostAddr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
    end else begin : g_notag
      assign inWindow = 1'b1;
    end
  endgenerate

  assign offset = hostAddr[OFF_W-1:0];
  assign kind   = classifyOffset(offset);
  assign wrGo   = inWindow && hostWr;
  assign rdGo   = inWindow && hostRd && !hostWr;

  always_comb begin
    strobe           = '0;
    strobe.blk       = BLK_NONE;
    strobe.rdSrc     = RSRC_ONES;
    strobe.rdCapture = rdGo;
    unique case (kind)
      KIND_WORD: begin
        strobe.devRd    = rdGo;
        strobe.devWr    = wrGo;
        strobe.blk      = (rdGo || wrGo) ? BLK_CMD : BLK_NONE;
        strobe.regIdx   = IDX_WORD;
        strobe.wordXfer = 1'b1;
        strobe.rdSrc    = RSRC_DEV;
      end
      KIND_PASS: begin
        strobe.devRd  = rdGo;
        strobe.devWr  = wrGo;
        strobe.blk    = (rdGo || wrGo) ? BLK_CMD : BLK_NONE;
        strobe.regIdx = offset[IDX_W-1:0];
        strobe.rdSrc  = RSRC_DEV;
      end
      KIND_CTRL: begin
        strobe.devRd  = rdGo;
        strobe.devWr  = wrGo;
        strobe.blk    = (rdGo || wrGo) ? BLK_CTL : BLK_NONE;
        strobe.regIdx = IDX_ALT;
        strobe.rdSrc  = RSRC_DEV;
      end
      KIND_HOLD: begin
        strobe.holdLoad = wrGo;
        strobe.rdSrc    = RSRC_HOLD;
      end
      default: begin
        strobe.rdSrc = RSRC_ONES;
      end
    endcase
  end
endmodule

// File: rtl/ibb_dp.sv
module ibb_dp
  import ibb_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [HOST_W-1:0]   hostWrData,
  input  logic [2*HOST_W-1:0] ataRdData,
  output logic [2*HOST_W-1:0] ataWrData,
  output logic [HOST_W-1:0]   hostRdData,
  output logic                hostRdOe
);
  localparam int ATA_W = 2 * HOST_W;

  logic [HOST_W-1:0] holdByte;
  logic [HOST_W-1:0] rdNext;
  logic              wordRead;

  assign wordRead  = strobe.devRd && strobe.wordXfer;
  assign ataWrData = strobe.wordXfer ? {holdByte, hostWrData}
                                     : {{HOST_W{1'b0}}, hostWrData};

  always_comb begin
    unique case (strobe.rdSrc)
      RSRC_DEV:  rdNext = ataRdData[HOST_W-1:0];
      RSRC_HOLD: rdNext = holdByte;
      default:   rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
    end else if (strobe.holdLoad) begin
      holdByte <= hostWrData;
    end else if (wordRead) begin
      holdByte <= ataRdData[ATA_W-1:HOST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      hostRdOe   <= 1'b0;
    end else begin
      hostRdOe <= strobe.rdCapture;
      if (strobe.rdCapture) begin
        hostRdData <= rdNext;
      end
    end
  end
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
  import ibb_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                HOST_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0300
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [HOST_W-1:0]   hostWrData,
  input  logic                hostRd,
  input  logic                hostWr,
  output logic [HOST_W-1:0]   hostRdData,
  output logic                hostRdOe,
  output logic                ataCmdSel,
  output logic                ataCtlSel,
  output logic [2:0]          ataRegAddr,
  output logic                ataRd,
  output logic                ataWr,
  output logic [2*HOST_W-1:0] ataWrData,
  input  logic [2*HOST_W-1:0] ataRdData
);
  ctlStrobe_t strobe;

  ibb_ctrl #(
    .ADDR_W(ADDR_W),
    .BASE  (BASE)
  ) u_ctrl (
    .hostAddr(hostAddr),
    .hostRd  (hostRd),
    .hostWr  (hostWr),
    .strobe  (strobe)
  );

  ibb_dp #(
    .HOST_W(HOST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWrData(hostWrData),
    .ataRdData (ataRdData),
    .ataWrData (ataWrData),
    .hostRdData(hostRdData),
    .hostRdOe  (hostRdOe)
  );

  assign ataCmdSel  = (strobe.blk == BLK_CMD);
  assign ataCtlSel  = (strobe.blk == BLK_CTL);
  assign ataRegAddr = strobe.regIdx;
  assign ataRd      = strobe.devRd;
  assign ataWr      = strobe.devWr;
endmodule

// File: rtl/ibb_checker.sv
module ibb_checker #(
  parameter int                ADDR_W = 16,
  parameter int                HOST_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0300
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   hostAddr,
  input logic [HOST_W-1:0]   hostWrData,
  input logic                hostRd,
  input logic                hostWr,
  input logic [HOST_W-1:0]   hostRdData,
  input logic                hostRdOe,
  input logic                ataCmdSel,
  input logic                ataCtlSel,
  input logic [2:0]          ataRegAddr,
  input logic                ataRd,
  input logic                ataWr,
  input logic [2*HOST_W-1:0] ataWrData,
  input logic [2*HOST_W-1:0] ataRdData
);
  logic       inWin;
  logic [3:0] off;
  logic       deadOff;

  assign inWin   = ((hostAddr >> 4) == (BASE >> 4));
  assign off     = hostAddr[3:0];
  assign deadOff = (off >= 4'd9 && off <= 4'd13) || (off == 4'd15);

  AST_DEV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (ataRd || ataWr) |-> (inWin && (hostRd || hostWr))); // R1
  AST_HOLD_NO_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && inWin && off == 4'd8) |-> (!ataRd && !ataWr)); // R2
  AST_WORD_WR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ataWr && ataCmdSel && ataRegAddr == 3'd0) |-> (ataWrData[HOST_W-1:0] == hostWrData)); // R3
  AST_WORD_RD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ataRd && ataCmdSel && ataRegAddr == 3'd0) |=> (hostRdOe && hostRdData == $past(ataRdData[HOST_W-1:0]))); // R4
  AST_HOLD_RD_NO_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && inWin && off == 4'd8) |-> (!ataRd && !ataWr)); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (ataRd || ataWr) |-> $onehot({ataCmdSel, ataCtlSel})); // R6
  AST_CTL_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    ataCtlSel |-> (ataRegAddr == 3'd6)); // R7
  AST_DEAD_NO_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && deadOff) |-> (!ataRd && !ataWr)); // R8
  AST_OE_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rstN)
    hostRdOe |-> $past(hostRd && !hostWr && inWin)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ataRd && ataWr)); // R11
endmodule

bind ide_byte_bridge ibb_checker #(
  .ADDR_W(ADDR_W),
  .HOST_W(HOST_W),
  .BASE  (BASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAddr  (hostAddr),
  .hostWrData(hostWrData),
  .hostRd    (hostRd),
  .hostWr    (hostWr),
  .hostRdData(hostRdData),
  .hostRdOe  (hostRdOe),
  .ataCmdSel (ataCmdSel),
  .ataCtlSel (ataCtlSel),
  .ataRegAddr(ataRegAddr),
  .ataRd     (ataRd),
  .ataWr     (ataWr),
  .ataWrData (ataWrData),
  .ataRdData (ataRdData)
);

// File: tb/tb_ide_byte_bridge.sv
module tb_ide_byte_bridge;
  localparam logic [15:0] BASE = 16'h0300;
  localparam logic [7:0]  ALT_STATUS = 8'h58;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostRdData;
  logic        hostRdOe;
  logic        ataCmdSel, ataCtlSel, ataRd, ataWr;
  logic [2:0]  ataRegAddr;
  logic [15:0] ataWrData;
  logic [15:0] ataRdData;

  logic [15:0] devRegs [8];
  logic [7:0]  devCtl;
  int          devRdCnt, devWrCnt;
  logic        pokeEn = 1'b0;
  logic [2:0]  pokeIdx = '0;
  logic [15:0] pokeVal = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ide_byte_bridge #(.ADDR_W(16), .HOST_W(8), .BASE(BASE)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostWr(hostWr), .hostRdData(hostRdData), .hostRdOe(hostRdOe),
    .ataCmdSel(ataCmdSel), .ataCtlSel(ataCtlSel), .ataRegAddr(ataRegAddr),
    .ataRd(ataRd), .ataWr(ataWr), .ataWrData(ataWrData), .ataRdData(ataRdData)
  );

  // Device register model
  always_comb begin
    if (ataCmdSel)      ataRdData = devRegs[ataRegAddr];
    else if (ataCtlSel) ataRdData = {8'h00, ALT_STATUS};
    else                ataRdData = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) devRegs[i] <= '0;
      devCtl   <= '0;
      devRdCnt <= 0;
      devWrCnt <= 0;
    end else begin
      if (pokeEn) devRegs[pokeIdx] <= pokeVal;
      if (ataRd) devRdCnt <= devRdCnt + 1;
      if (ataWr) begin
        devWrCnt <= devWrCnt + 1;
        if (ataCmdSel)      devRegs[ataRegAddr] <= ataWrData;
        else if (ataCtlSel) devCtl <= ataWrData[7:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdData; oe = hostRdOe;
  endtask

  task automatic poke(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = idx; pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d; logic oe;
    check(hostRdOe == 1'b0, "R10", "oe after reset", hostRdOe, 0);
    check(!ataRd && !ataWr, "R10", "no strobe after reset", {ataRd, ataWr}, 0);
    hostRead(BASE | 16'd8, d, oe);
    check(oe && d == 8'h00, "R9", "hold byte after reset", d, 0);
    check(devRdCnt == 0, "R5", "hold read device reads", devRdCnt, 0);
  endtask

  task automatic testWordWrite();
    logic [7:0] d; logic oe;
    int w0;
    w0 = devWrCnt;
    hostWrite(BASE | 16'd8, 8'h5A);
    check(devWrCnt == w0 && devRdCnt == 0, "R2", "hold write device strobes", devWrCnt - w0, 0);
    hostRead(BASE | 16'd8, d, oe);
    check(d == 8'h5A, "R2", "hold byte readback", d, 8'h5A);
    hostWrite(BASE | 16'd0, 8'h3C);
    check(devRegs[0] == 16'h5A3C, "R3", "word write", devRegs[0], 16'h5A3C);
    check(devWrCnt == w0 + 1, "R3", "one device write", devWrCnt - w0, 1);
  endtask

  task automatic testWordRead();
    logic [7:0] d; logic oe;
    int r0;
    poke(3'd0, 16'hBEEF);
    r0 = devRdCnt;
    hostRead(BASE | 16'd0, d, oe);
    check(oe && d == 8'hEF, "R4", "word read low byte", d, 8'hEF);
    check(devRdCnt == r0 + 1, "R10", "one device read", devRdCnt - r0, 1);
    @(negedge clk);
    check(hostRdOe == 1'b0, "R10", "oe single cycle", hostRdOe, 0);
    hostRead(BASE | 16'd8, d, oe);
    check(d == 8'hBE, "R4", "high byte parked", d, 8'hBE);
    check(devRdCnt == r0 + 1, "R5", "hold read no device read", devRdCnt - r0, 1);
  endtask

  task automatic testPassThrough();
    logic [7:0] d; logic oe;
    for (int i = 1; i < 8; i++) begin
      hostWrite(BASE | 16'(i), 8'(8'h10 + i));
      check(devRegs[i] == {8'h00, 8'(8'h10 + i)}, "R6", "pass write", devRegs[i], 8'h10 + i);
    end
    for (int i = 1; i < 8; i++) begin
      poke(3'(i), {8'h7F, 8'(8'h20 + i)});
      hostRead(BASE | 16'(i), d, oe);
      check(oe && d == 8'(8'h20 + i), "R6", "pass read", d, 8'h20 + i);
    end
  endtask

  task automatic testControl();
    logic [7:0] d; logic oe;
    hostWrite(BASE | 16'd14, 8'h0A);
    check(devCtl == 8'h0A, "R7", "device control write", devCtl, 8'h0A);
    hostRead(BASE | 16'd14, d, oe);
    check(oe && d == ALT_STATUS, "R7", "alternate status read", d, ALT_STATUS);
  endtask

  task automatic testDead();
    logic [7:0] d; logic oe;
    int w0, r0;
    for (int o = 9; o < 16; o++) begin
      if (o == 14) continue;
      w0 = devWrCnt; r0 = devRdCnt;
      hostWrite(BASE | 16'(o), 8'hC3);
      hostRead(BASE | 16'(o), d, oe);
      check(d == 8'hFF && oe, "R8", "dead offset read", d, 8'hFF);
      check(devWrCnt == w0 && devRdCnt == r0, "R8", "dead offset strobes", devWrCnt - w0, 0);
    end
    hostRead(BASE | 16'd8, d, oe);
    check(d == 8'hBE, "R8", "hold byte untouched", d, 8'hBE);
  endtask

  task automatic testOutside();
    logic [7:0] d; logic oe;
    int w0, r0;
    w0 = devWrCnt; r0 = devRdCnt;
    hostWrite(BASE + 16'h0010, 8'h99);
    hostWrite(BASE + 16'h0108, 8'h99);
    hostRead(BASE + 16'h0010, d, oe);
    check(oe == 1'b0, "R1", "oe outside window", oe, 0);
    check(devWrCnt == w0 && devRdCnt == r0, "R1", "no strobe outside", devWrCnt - w0, 0);
    hostRead(BASE | 16'd8, d, oe);
    check(d == 8'hBE, "R1", "hold unaffected from outside", d, 8'hBE);
  endtask

  task automatic testCollision();
    int r0;
    r0 = devRdCnt;
    @(negedge clk);
    hostAddr = BASE | 16'd3; hostWrData = 8'h77; hostRd = 1'b1; hostWr = 1'b1;
    @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0;
    check(devRegs[3] == 16'h0077, "R11", "write served", devRegs[3], 16'h0077);
    check(devRdCnt == r0, "R11", "read dropped", devRdCnt - r0, 0);
    check(hostRdOe == 1'b0, "R11", "no oe on collision", hostRdOe, 0);
  endtask

  task automatic testHoldShared();
    logic [7:0] d; logic oe;
    hostWrite(BASE | 16'd8, 8'h11);
    poke(3'd0, 16'h2233);
    hostRead(BASE | 16'd0, d, oe);
    hostWrite(BASE | 16'd0, 8'h44);
    check(devRegs[0] == 16'h2244, "R9", "read loaded hold last", devRegs[0], 16'h2244);
    hostWrite(BASE | 16'd8, 8'h66);
    hostWrite(BASE | 16'd0, 8'h55);
    check(devRegs[0] == 16'h6655, "R9", "write loaded hold last", devRegs[0], 16'h6655);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordWrite();
    testWordRead();
    testPassThrough();
    testControl();
    testDead();
    testOutside();
    testCollision();
    testHoldShared();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule